// File: doc/BRIEF.md
# Rotate, Shift and Single-Bit Manipulation Unit

This block is the purely combinational datapath slice that carries out the prefixed rotate/shift group and the single-bit instructions of an 8-bit processor core. It receives an operand byte and the flag byte currently held by the core. It also receives three selects: an operation class, a shift/rotate variant and a bit index. In the same cycle it returns the new data byte, the new flag byte and a write-back enable.

There are four classes. The shift/rotate class offers eight variants, including the undocumented left shift that fills bit 0 with a one. The test class only examines one bit and sets the flags. The clear class and the set class modify one bit. Instruction decode, the register file, memory access and cycle sequencing belong to the surrounding core. There is no clock, no reset and no state inside the block.

Flag byte layout, most significant bit first: sign (7), zero (6), reserved (5), half-carry (4), reserved (3), parity (2), subtract (1), carry (0).

Top module: `rsb_unit`

## Requirements
- R1: Class 0 with variant 0 (circular left) returns the operand rotated left by one, with old bit 7 in bit 0 and in carry. Variant 1 (circular right) rotates right, with old bit 0 in bit 7 and in carry.
- R2: Class 0 with variant 2 (left through carry) shifts left, fills bit 0 with the incoming carry (flag bit 0) and puts old bit 7 in carry. Variant 3 (right through carry) shifts right, fills bit 7 with the incoming carry and puts old bit 0 in carry.
- R3: Class 0 with variant 4 shifts left and fills with zero. Variant 5 shifts right and keeps bit 7. Variant 7 shifts right and fills bit 7 with zero. In all three, the bit shifted out becomes carry.
- R4: Class 0 with variant 6 shifts left, fills bit 0 with one and puts old bit 7 in carry.
- R5: In class 0 the flag byte is rebuilt with no dependence on incoming flags other than the carry used by R2. Sign is result bit 7, zero is set exactly when the result is 0x00, bit 2 is 1 when the result has an even count of ones, and carry is as above. Bits 5, 4, 3 and 1 are 0.
- R6: Class 1 (test) returns the operand unchanged and sets zero (bit 6) exactly when the indexed bit is 0. It sets half-carry (bit 4) and clears subtract (bit 1). Every other flag bit, carry included, passes through unchanged.
- R7: The write-back enable is 0 in class 1 and 1 in classes 0, 2 and 3.
- R8: Class 2 (clear) forces the indexed bit to 0, leaves the other bits and the whole flag byte unchanged.
- R9: Class 3 (set) forces the indexed bit to 1, leaves the other bits and the whole flag byte unchanged.
- R10: The variant select has no effect in classes 1 to 3, and the bit index has no effect in class 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | 8 | Operand byte |
| flags_i | input | 8 | Current flag byte |
| variant_i | input | 3 | Shift/rotate variant, 0 to 7 as listed in R1 to R4 |
| class_i | input | 2 | 0 shift/rotate, 1 test, 2 clear, 3 set |
| bit_idx_i | input | 3 | Bit position for classes 1 to 3 |
| result_o | output | 8 | Result byte |
| flags_o | output | 8 | New flag byte |
| wr_en_o | output | 1 | Write the result back to the operand's home |

## Verification
The bound checker watches several relations on every input combination the bench applies. These are the cleared half-carry, subtract and reserved bits, and the parity and zero flags agreeing with the shifted result. They also cover the test class keeping carry and the data byte, the write-back enable per class, and clear/set touching only the indexed bit while keeping the flag byte. Only the bench's vectors can show which fill bit and carry each of the eight variants produces. The same holds for the carry feeding the through-carry rotates and for variant and index being ignored where they do not apply, since checking these needs expected values worked out by hand.

// File: rtl/rsb_pkg.sv
package rsb_pkg;

    localparam int FLAG_W   = 8;
    localparam int FLG_SIGN = 7;
    localparam int FLG_ZERO = 6;
    localparam int FLG_RSV5 = 5;
    localparam int FLG_HALF = 4;
    localparam int FLG_RSV3 = 3;
    localparam int FLG_PAR  = 2;
    localparam int FLG_SUB  = 1;
    localparam int FLG_CARRY = 0;

    typedef enum logic [2:0] {
        VAR_ROL_CIRC  = 3'd0,
        VAR_ROR_CIRC  = 3'd1,
        VAR_ROL_CARRY = 3'd2,
        VAR_ROR_CARRY = 3'd3,
        VAR_SHL_ZERO  = 3'd4,
        VAR_SHR_ARITH = 3'd5,
        VAR_SHL_ONE   = 3'd6,
        VAR_SHR_LOGIC = 3'd7
    } variant_e;

    typedef enum logic [1:0] {
        CLS_SHIFT = 2'd0,
        CLS_TEST  = 2'd1,
        CLS_CLEAR = 2'd2,
        CLS_SET   = 2'd3
    } class_e;

endpackage

// File: rtl/rsb_shifter.sv
module rsb_shifter
    import rsb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] operand_i,
    input  logic              carry_i,
    input  variant_e          variant_i,
    output logic [DATA_W-1:0] result_o,
    output logic              carry_o
);

    logic msb;
    logic lsb;
    logic fill;
    logic go_left;

    assign msb = operand_i[DATA_W-1];
    assign lsb = operand_i[0];

    // Direction and the bit entering the vacated end, per variant.
    always_comb begin
        unique case (variant_i)
            VAR_ROL_CIRC:  begin go_left = 1'b1; fill = msb;     end
            VAR_ROR_CIRC:  begin go_left = 1'b0; fill = lsb;     end
            VAR_ROL_CARRY: begin go_left = 1'b1; fill = carry_i; end
            VAR_ROR_CARRY: begin go_left = 1'b0; fill = carry_i; end
            VAR_SHL_ZERO:  begin go_left = 1'b1; fill = 1'b0;    end
            VAR_SHR_ARITH: begin go_left = 1'b0; fill = msb;     end
            VAR_SHL_ONE:   begin go_left = 1'b1; fill = 1'b1;    end
            VAR_SHR_LOGIC: begin go_left = 1'b0; fill = 1'b0;    end
        endcase
    end

    always_comb begin
        if (go_left) begin
            result_o = {operand_i[DATA_W-2:0], fill};
            carry_o  = msb;
        end else begin
            result_o = {fill, operand_i[DATA_W-1:1]};
            carry_o  = lsb;
        end
    end

endmodule

// File: rtl/rsb_bitops.sv
module rsb_bitops #(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] operand_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [DATA_W-1:0] cleared_o,
    output logic [DATA_W-1:0] setted_o,
    output logic              tested_o
);

    logic [DATA_W-1:0] onehot;

    // One decoder leg per bit position.
    for (genvar b = 0; b < DATA_W; b++) begin : g_dec
        assign onehot[b]    = (idx_i == IDX_W'(b));
        assign cleared_o[b] = operand_i[b] & ~onehot[b];
        assign setted_o[b]  = operand_i[b] |  onehot[b];
    end

    assign tested_o = |(operand_i & onehot);

endmodule

// File: rtl/rsb_flags.sv
module rsb_flags
    import rsb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  class_e            class_i,
    input  logic [FLAG_W-1:0] flags_i,
    input  logic [DATA_W-1:0] shift_res_i,
    input  logic              shift_carry_i,
    input  logic              tested_i,
    output logic [FLAG_W-1:0] flags_o
);

    logic even_ones;

    assign even_ones = ~^shift_res_i;

    always_comb begin
        flags_o = flags_i;
        unique case (class_i)
            CLS_SHIFT: begin
                flags_o            = '0;
                flags_o[FLG_SIGN]  = shift_res_i[DATA_W-1];
                flags_o[FLG_ZERO]  = (shift_res_i == '0);
                flags_o[FLG_PAR]   = even_ones;
                flags_o[FLG_CARRY] = shift_carry_i;
            end
            CLS_TEST: begin
                flags_o[FLG_ZERO] = ~tested_i;
                flags_o[FLG_HALF] = 1'b1;
                flags_o[FLG_SUB]  = 1'b0;
            end
            CLS_CLEAR, CLS_SET: flags_o = flags_i;
        endcase
    end

endmodule

// File: rtl/rsb_unit.sv
module rsb_unit
    import rsb_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] operand_i,
    input  logic [FLAG_W-1:0] flags_i,
    input  logic [2:0]        variant_i,
    input  logic [1:0]        class_i,
    input  logic [IDX_W-1:0]  bit_idx_i,
    output logic [DATA_W-1:0] result_o,
    output logic [FLAG_W-1:0] flags_o,
    output logic              wr_en_o
);

    class_e            cls;
    variant_e          var_sel;
    logic [DATA_W-1:0] shift_res;
    logic              shift_carry;
    logic [DATA_W-1:0] cleared;
    logic [DATA_W-1:0] setted;
    logic              tested;

    assign cls     = class_e'(class_i);
    assign var_sel = variant_e'(variant_i);

    rsb_shifter #(.DATA_W(DATA_W)) u_shift (
        .operand_i (operand_i),
        .carry_i   (flags_i[FLG_CARRY]),
        .variant_i (var_sel),
        .result_o  (shift_res),
        .carry_o   (shift_carry)
    );

    rsb_bitops #(.DATA_W(DATA_W)) u_bits (
        .operand_i (operand_i),
        .idx_i     (bit_idx_i),
        .cleared_o (cleared),
        .setted_o  (setted),
        .tested_o  (tested)
    );

    rsb_flags #(.DATA_W(DATA_W)) u_flags (
        .class_i       (cls),
        .flags_i       (flags_i),
        .shift_res_i   (shift_res),
        .shift_carry_i (shift_carry),
        .tested_i      (tested),
        .flags_o       (flags_o)
    );

    always_comb begin
        unique case (cls)
            CLS_SHIFT: begin result_o = shift_res; wr_en_o = 1'b1; end
            CLS_TEST:  begin result_o = operand_i; wr_en_o = 1'b0; end
            CLS_CLEAR: begin result_o = cleared;   wr_en_o = 1'b1; end
            CLS_SET:   begin result_o = setted;    wr_en_o = 1'b1; end
        endcase
    end

endmodule

// File: rtl/rsb_unit_chk.sv
module rsb_unit_chk
    import rsb_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input logic [DATA_W-1:0] operand_i,
    input logic [FLAG_W-1:0] flags_i,
    input logic [1:0]        class_i,
    input logic [IDX_W-1:0]  bit_idx_i,
    input logic [DATA_W-1:0] result_o,
    input logic [FLAG_W-1:0] flags_o,
    input logic              wr_en_o
);

    always_comb begin
        if (class_i == 2'd1) begin
            AST_TEST_NO_WRITE: assert (!wr_en_o); // R7
            AST_TEST_KEEPS_DATA: assert (result_o == operand_i && flags_o[FLG_CARRY] == flags_i[FLG_CARRY] && flags_o[FLG_HALF] && !flags_o[FLG_SUB]); // R6
            AST_TEST_ZERO_FLAG: assert (flags_o[FLG_ZERO] == !operand_i[bit_idx_i]); // R6
        end else begin
            AST_MODIFY_WRITES: assert (wr_en_o); // R7
        end
        if (class_i == 2'd0) begin
            AST_SHIFT_CLEARED_BITS: assert (!flags_o[FLG_HALF] && !flags_o[FLG_SUB] && !flags_o[FLG_RSV5] && !flags_o[FLG_RSV3]); // R5
            AST_SHIFT_PARITY: assert (flags_o[FLG_PAR] == !(^result_o)); // R5
            AST_SHIFT_ZERO_SIGN: assert (flags_o[FLG_ZERO] == (result_o == '0) && flags_o[FLG_SIGN] == result_o[DATA_W-1]); // R5
        end
        if (class_i[1]) begin
            AST_BITOP_FLAGS_KEPT: assert (flags_o == flags_i); // R8
            AST_BITOP_ONE_BIT: assert ($countones(result_o ^ operand_i) <= 1 && result_o[bit_idx_i] == class_i[0]); // R9
        end
    end

endmodule

bind rsb_unit rsb_unit_chk u_chk (
    .operand_i (operand_i),
    .flags_i   (flags_i),
    .class_i   (class_i),
    .bit_idx_i (bit_idx_i),
    .result_o  (result_o),
    .flags_o   (flags_o),
    .wr_en_o   (wr_en_o)
);

// File: tb/rsb_unit_tb.sv
module rsb_unit_tb;

    logic       clk = 1'b0;
    logic [7:0] operand;
    logic [7:0] flags_in;
    logic [2:0] variant;
    logic [1:0] cls;
    logic [2:0] idx;
    logic [7:0] result;
    logic [7:0] flags_out;
    logic       wr_en;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    rsb_unit u_dut (
        .operand_i (operand),
        .flags_i   (flags_in),
        .variant_i (variant),
        .class_i   (cls),
        .bit_idx_i (idx),
        .result_o  (result),
        .flags_o   (flags_out),
        .wr_en_o   (wr_en)
    );

    // {class, variant, index, operand, flags_in, exp_result, exp_flags, exp_wr}
    localparam int NV = 18;
    localparam logic [40:0] VEC [0:NV-1] = '{
        {2'd0, 3'd0, 3'd5, 8'h85, 8'h00, 8'h0B, 8'h01, 1'b1}, // R1 circular left
        {2'd0, 3'd1, 3'd2, 8'h01, 8'hFF, 8'h80, 8'h81, 1'b1}, // R1 circular right
        {2'd0, 3'd2, 3'd0, 8'h80, 8'h01, 8'h01, 8'h01, 1'b1}, // R2 left, carry in 1
        {2'd0, 3'd2, 3'd7, 8'h80, 8'h00, 8'h00, 8'h45, 1'b1}, // R2 left, carry in 0
        {2'd0, 3'd3, 3'd1, 8'h02, 8'h01, 8'h81, 8'h84, 1'b1}, // R2 right, carry in 1
        {2'd0, 3'd4, 3'd3, 8'hFF, 8'h00, 8'hFE, 8'h81, 1'b1}, // R3 left zero fill
        {2'd0, 3'd5, 3'd6, 8'h81, 8'h00, 8'hC0, 8'h85, 1'b1}, // R3 arithmetic right
        {2'd0, 3'd7, 3'd4, 8'h01, 8'hFE, 8'h00, 8'h45, 1'b1}, // R3 logical right to zero
        {2'd0, 3'd6, 3'd0, 8'h80, 8'h00, 8'h01, 8'h01, 1'b1}, // R4 one fill
        {2'd0, 3'd6, 3'd2, 8'h3C, 8'h01, 8'h79, 8'h00, 1'b1}, // R4 one fill, carry out 0
        {2'd0, 3'd7, 3'd0, 8'h06, 8'hFF, 8'h03, 8'h04, 1'b1}, // R5 stale flags dropped
        {2'd1, 3'd5, 3'd3, 8'h08, 8'h01, 8'h08, 8'h11, 1'b0}, // R6 bit set
        {2'd1, 3'd2, 3'd7, 8'h7F, 8'hAB, 8'h7F, 8'hF9, 1'b0}, // R6 bit clear
        {2'd1, 3'd7, 3'd0, 8'hFE, 8'h42, 8'hFE, 8'h50, 1'b0}, // R6 index 0
        {2'd2, 3'd1, 3'd5, 8'hFF, 8'h5A, 8'hDF, 8'h5A, 1'b1}, // R8 clear bit 5
        {2'd2, 3'd6, 3'd0, 8'h01, 8'h00, 8'h00, 8'h00, 1'b1}, // R8 zero result, flags kept
        {2'd3, 3'd3, 3'd7, 8'h00, 8'h00, 8'h80, 8'h00, 1'b1}, // R9 set bit 7
        {2'd3, 3'd0, 3'd2, 8'h04, 8'hC3, 8'h04, 8'hC3, 1'b1}  // R9 already set
    };
    localparam int VREQ [0:NV-1] = '{1, 1, 2, 2, 2, 3, 3, 3, 4, 4, 5, 6, 6, 6, 8, 8, 9, 9};

    task automatic apply(input logic [1:0] c, input logic [2:0] v, input logic [2:0] i,
                         input logic [7:0] a, input logic [7:0] f);
        @(posedge clk);
        cls = c; variant = v; idx = i; operand = a; flags_in = f;
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] er, input logic [7:0] ef,
                         input logic ew);
        n_chk++;
        if (result !== er || flags_out !== ef || wr_en !== ew) begin
            n_fail++;
            $display("FAIL %s: result %h flags %h wr %b, expected %h %h %b",
                     req, result, flags_out, wr_en, er, ef, ew);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        cls = 2'd0; variant = 3'd0; idx = 3'd0; operand = 8'h00; flags_in = 8'h00;

        // Idle inputs: zero byte circular left gives zero with zero and parity flags (R5)
        apply(2'd0, 3'd0, 3'd0, 8'h00, 8'h00);
        check("R5 idle", 8'h00, 8'h44, 1'b1);

        for (int k = 0; k < NV; k++) begin
            apply(VEC[k][40:39], VEC[k][38:36], VEC[k][35:33], VEC[k][32:25], VEC[k][24:17]);
            check($sformatf("R%0d vector %0d", VREQ[k], k), VEC[k][16:9], VEC[k][8:1], VEC[k][0]);
        end

        // R5 and R1: every operand through circular left with all flags set on entry
        for (int a = 0; a < 256; a++) begin
            logic [7:0] op8;
            logic [7:0] er;
            logic [7:0] ef;
            op8 = 8'(a);
            er  = {op8[6:0], op8[7]};
            ef  = {er[7], (er == 8'h00), 3'b000, ~^er, 1'b0, op8[7]};
            apply(2'd0, 3'd0, 3'd1, op8, 8'hFF);
            check("R5 parity sweep", er, ef, 1'b1);
        end

        // R10: variant ignored in set class
        for (int v = 0; v < 8; v++) begin
            apply(2'd3, 3'(v), 3'd4, 8'h21, 8'h96);
            check("R10 variant ignored", 8'h31, 8'h96, 1'b1);
        end

        // R10: index ignored in shift class
        for (int i = 0; i < 8; i++) begin
            apply(2'd0, 3'd5, 3'(i), 8'h40, 8'h00);
            check("R10 index ignored", 8'h20, 8'h00, 1'b1);
        end

        // R7: test class never writes back, whatever the variant
        for (int v = 0; v < 8; v++) begin
            apply(2'd1, 3'(v), 3'd6, 8'h40, 8'h00);
            check("R7 test no write", 8'h40, 8'h10, 1'b0);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule